// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Masking

This block watches a running calendar clock and raises an alarm when it reaches a programmed point. The calendar and time come in as five BCD fields: month, date, hour, minute and second. Five alarm registers hold a target value for each field. Each alarm register also carries one repeat bit. The repeat bits decide which fields take part in the comparison. The comparison runs only on a once-per-second update strobe, so one matching second produces exactly one alarm event.

When the enabled fields match, the block sets an alarm flag. If the flag enable is also set, it pulls an active-low interrupt pin. In backup mode the pin needs a second, separate enable. Software clears the interrupt and the flag by reading the flags register twice: the first read releases the pin and the second read clears the flag.

The pin is shared with a watchdog interrupt request and a frequency-test waveform. Both interrupt sources take priority over the waveform.

Top module: `rtc_alarm_top`

## Requirements
- R1: The alarm registers sit at these addresses, each laid out as a repeat bit in bit 7 over a BCD value: 2h second, 3h minute, 4h hour, 5h date, 6h month. The control register at 1h holds the flag enable in bit 7 and the backup enable in bit 6. All six registers read back what was last written. The flags register at 0h reports the alarm flag in bit 6. Unused bits and unused addresses read 0.
- R2: With all repeat bits clear, the alarm flag sets only on a strobe in which the month, date, hour, minute and second all equal their alarm values. It is visible on the flags register from the cycle after that strobe. A mismatch in any field, or a match without a strobe, leaves the flag clear.
- R3: Repeat bits set on the k coarsest fields, counting down from month through date, hour and minute to second, exclude exactly those fields from the comparison. This gives k = 0 yearly, 1 monthly, 2 daily, 3 hourly, 4 every minute and 5 every second.
- R4: Any repeat pattern that does not have that contiguous coarse-first shape fires on every strobe.
- R5: When the date alarm value is zero and the repeat bits of month, date, hour and minute are all clear, the alarm never fires, whatever the second's repeat bit is.
- R6: Outside backup mode, an alarm event drives the interrupt pin low from the next cycle only when the flag enable is 1. With the enable at 0, only the flag sets.
- R7: In backup mode, an alarm event drives the pin low only when both the flag enable and the backup enable are 1.
- R8: The first read of the flags register after an alarm event returns bit 6 set and releases the pin from the next cycle. The second read also returns bit 6 set and clears the flag. A later read returns 0.
- R9: Reset clears the control enables, all alarm registers, the flag and the interrupt. If the alarm registers are reprogrammed after reset without touching the control register, an alarm sets only the flag and leaves the pin high.
- R10: The pin is low while an alarm interrupt or the watchdog request is active. Otherwise it follows the frequency-test waveform when frequency test is enabled, and it is high when frequency test is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reading the flags register has side effects) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| sec_tick | input | 1 | One-cycle strobe marking a new second |
| now_sec | input | DATA_W | Current second, BCD |
| now_min | input | DATA_W | Current minute, BCD |
| now_hour | input | DATA_W | Current hour, BCD |
| now_date | input | DATA_W | Current date, BCD |
| now_month | input | DATA_W | Current month, BCD |
| backup_mode | input | 1 | Backup-supply mode indicator |
| wdog_irq | input | 1 | Watchdog interrupt request to the shared pin |
| ftest_en | input | 1 | Frequency-test output enabled |
| ftest_wave | input | 1 | Frequency-test waveform |
| irq_ft_n | output | 1 | Shared active-low interrupt / frequency-test pin |

## Verification
A wrong repeat decode or a wrong field compare shows up as a flags-register bit 6 that is set or clear against expectation on the read that follows the strobe, which is one cycle after the tick. Errors in the flag and interrupt state show on irq_ft_n in the cycle after the strobe or after a flags read. A wrong clear-sequence counter only shows on the second or third flags read. For that reason every alarm scenario reads the flags register three times in a row.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int unsigned NFIELD   = 5;   // sec, min, hour, date, month
    localparam int unsigned F_DATE   = 3;
    localparam int unsigned RPT_BIT  = 7;
    localparam int unsigned AF_BIT   = 6;
    localparam int unsigned AFE_BIT  = 7;
    localparam int unsigned ABE_BIT  = 6;
    localparam int unsigned ADR_FLAGS = 0;
    localparam int unsigned ADR_CTRL  = 1;
    localparam int unsigned ADR_ALM0  = 2;  // first alarm register (seconds)

    // significant BCD bits per field index
    function automatic int unsigned field_width(input int unsigned idx);
        case (idx)
            0, 1:    return 7;
            2, 3:    return 6;
            default: return 5;
        endcase
    endfunction

    typedef struct packed {
        logic af;
        logic irq;
        logic pend;   // one flags read seen since last event
    } flag_state_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [NFIELD-1:0][DATA_W-1:0] alm_o,
    output logic                          afe_o,
    output logic                          abe_o
);
    typedef struct packed {
        logic [NFIELD-1:0][DATA_W-1:0] alm;
        logic                          afe;
        logic                          abe;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            if (addr_i == ADDR_W'(ADR_CTRL)) begin
                regs_d.afe = wdata_i[AFE_BIT];
                regs_d.abe = wdata_i[ABE_BIT];
            end
            for (int i = 0; i < NFIELD; i++) begin
                if (addr_i == ADDR_W'(ADR_ALM0 + i)) regs_d.alm[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign alm_o = regs_q.alm;
    assign afe_o = regs_q.afe;
    assign abe_o = regs_q.abe;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [NFIELD-1:0][DATA_W-1:0] alm_i,
    input  logic [NFIELD-1:0][DATA_W-1:0] now_i,
    output logic                          match_o,
    output logic                          code_ok_o,
    output logic                          off_o
);
    localparam int unsigned DATE_W = field_width(F_DATE);

    logic [NFIELD-1:0] rpt;
    logic [NFIELD-1:0] eq;
    logic [NFIELD-1:0] care;

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        localparam int unsigned W = field_width(g);
        assign rpt[g] = alm_i[g][RPT_BIT];
        assign eq[g]  = (alm_i[g][W-1:0] == now_i[g][W-1:0]);
    end

    // legal codes: a coarser field is masked whenever a finer one is
    assign code_ok_o = ((rpt[NFIELD-2:0] & ~rpt[NFIELD-1:1]) == '0);
    assign care      = code_ok_o ? ~rpt : '0;
    assign match_o   = &(eq | ~care);
    assign off_o     = (alm_i[F_DATE][DATE_W-1:0] == '0) && (rpt[NFIELD-1:1] == '0);
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic flags_rd_i,
    input  logic afe_i,
    input  logic abe_i,
    input  logic backup_i,
    output logic af_o,
    output logic irq_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flags_rd_i) begin
            st_d.irq = 1'b0;
            if (st_q.af) begin
                if (st_q.pend) begin
                    st_d.af   = 1'b0;
                    st_d.pend = 1'b0;
                end else begin
                    st_d.pend = 1'b1;
                end
            end
        end
        if (hit_i) begin
            st_d.af   = 1'b1;
            st_d.pend = 1'b0;
            if (afe_i && (!backup_i || abe_i)) st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign af_o  = st_q.af;
    assign irq_o = st_q.irq;

    a_r6_irq_needs_afe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(afe_i));
    a_r7_backup_needs_abe: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.irq) && $past(backup_i)) |-> $past(abe_i));
    a_r8_read_releases_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd_i && !hit_i) |=> !st_q.irq);
    a_r8_af_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.af) |-> $past(flags_rd_i));
    a_r8_irq_implies_af: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.af);
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sec_tick,
    input  logic [DATA_W-1:0] now_sec,
    input  logic [DATA_W-1:0] now_min,
    input  logic [DATA_W-1:0] now_hour,
    input  logic [DATA_W-1:0] now_date,
    input  logic [DATA_W-1:0] now_month,
    input  logic              backup_mode,
    input  logic              wdog_irq,
    input  logic              ftest_en,
    input  logic              ftest_wave,
    output logic              irq_ft_n
);
    logic [NFIELD-1:0][DATA_W-1:0] alm;
    logic [NFIELD-1:0][DATA_W-1:0] now_v;
    logic afe, abe, match, code_ok, off, hit, flags_rd, af, irq;

    assign now_v    = {now_month, now_date, now_hour, now_min, now_sec};
    assign flags_rd = reg_rd && (reg_addr == ADDR_W'(ADR_FLAGS));
    assign hit      = sec_tick && match && !off;

    rtc_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .alm_o(alm), .afe_o(afe), .abe_o(abe)
    );

    rtc_alarm_match #(.DATA_W(DATA_W)) match_i (
        .alm_i(alm), .now_i(now_v), .match_o(match),
        .code_ok_o(code_ok), .off_o(off)
    );

    rtc_alarm_flags flags_i (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .flags_rd_i(flags_rd),
        .afe_i(afe), .abe_i(abe), .backup_i(backup_mode),
        .af_o(af), .irq_o(irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADR_FLAGS)) begin
            reg_rdata[AF_BIT] = af;
        end else if (reg_addr == ADDR_W'(ADR_CTRL)) begin
            reg_rdata[AFE_BIT] = afe;
            reg_rdata[ABE_BIT] = abe;
        end else begin
            for (int i = 0; i < NFIELD; i++) begin
                if (reg_addr == ADDR_W'(ADR_ALM0 + i)) reg_rdata = alm[i];
            end
        end
    end

    always_comb begin
        if (irq || wdog_irq) irq_ft_n = 1'b0;
        else if (ftest_en)   irq_ft_n = ftest_wave;
        else                 irq_ft_n = 1'b1;
    end

    a_r2_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> af);
    a_r4_bad_code_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !code_ok && !off) |=> af);
    a_r5_off_never_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (off && !af) |=> !$rose(af));
endmodule

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       sec_tick = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0, now_month = '0;
    logic       backup_mode = 1'b0, wdog_irq = 1'b0, ftest_en = 1'b0, ftest_wave = 1'b0;
    logic       irq_ft_n;

    int vectors = 0;
    int errors  = 0;

    // base alarm: month 12, date 25, 08:30:45 ; index 0=sec .. 4=month
    logic [7:0] base [5] = '{8'h45, 8'h30, 8'h08, 8'h25, 8'h12};

    always #4 clk = ~clk;

    rtc_alarm_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sec_tick(sec_tick), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_date(now_date), .now_month(now_month),
        .backup_mode(backup_mode), .wdog_irq(wdog_irq), .ftest_en(ftest_en),
        .ftest_wave(ftest_wave), .irq_ft_n(irq_ft_n)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dt, input logic [7:0] mo);
        now_sec = s; now_min = m; now_hour = h; now_date = dt; now_month = mo;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // three reads: expect flag on first two when set, always 0 on the third
    task automatic flag_seq(input string req, input logic exp_af);
        logic [7:0] d;
        rd(4'h0, d); chk(req, d, exp_af ? 8'h40 : 8'h00);
        rd(4'h0, d); chk(req, d, exp_af ? 8'h40 : 8'h00);
        rd(4'h0, d); chk(req, d, 8'h00);
    endtask

    task automatic prog(input logic [4:0] rpt, input logic [7:0] date_v);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] v;
            v = (i == 3) ? date_v : base[i];
            wr(4'(2 + i), v | (rpt[i] ? 8'h80 : 8'h00));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();   // R9 reset state
        logic [7:0] d;
        for (int a = 0; a < 7; a++) begin
            rd(4'(a), d); chk("R9 reset register", d, 8'h00);
        end
        chk("R9 reset pin", {7'b0, irq_ft_n}, 8'h01);
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        tick();
        flag_seq("R5 cleared regs disable alarm", 1'b0);
    endtask

    task automatic t_regs();    // R1
        logic [7:0] d;
        for (int i = 0; i < 5; i++) wr(4'(2 + i), 8'h81 + 8'(i * 17));
        wr(4'h1, 8'hFF);
        for (int i = 0; i < 5; i++) begin
            rd(4'(2 + i), d); chk("R1 alarm readback", d, 8'h81 + 8'(i * 17));
        end
        rd(4'h1, d); chk("R1 control readback", d, 8'hC0);
        rd(4'h9, d); chk("R1 unused address", d, 8'h00);
        wr(4'h1, 8'h00);
    endtask

    task automatic t_exact();   // R2
        prog(5'b00000, base[3]);
        set_time(base[0], base[1], base[2], base[3], base[4]);
        repeat (3) @(negedge clk);
        flag_seq("R2 match without tick", 1'b0);
        set_time(base[0], 8'h31, base[2], base[3], base[4]);
        tick();
        flag_seq("R2 minute mismatch", 1'b0);
        set_time(base[0], base[1], base[2], base[3], 8'h11);
        tick();
        flag_seq("R2 month mismatch", 1'b0);
        set_time(base[0], base[1], base[2], base[3], base[4]);
        tick();
        flag_seq("R2 exact match", 1'b1);
    endtask

    task automatic t_repeat();  // R3
        for (int n = 0; n <= 5; n++) begin
            logic [4:0] rpt;
            logic [7:0] tv [5];
            rpt = 5'b0;
            for (int i = 0; i < 5; i++) rpt[i] = (i >= 5 - n);
            prog(rpt, base[3]);
            for (int i = 0; i < 5; i++) tv[i] = rpt[i] ? (base[i] ^ 8'h01) : base[i];
            set_time(tv[0], tv[1], tv[2], tv[3], tv[4]);
            tick();
            flag_seq($sformatf("R3 repeat level %0d hit", n), 1'b1);
            if (n < 5) begin
                tv[4 - n] = base[4 - n] ^ 8'h02;
                set_time(tv[0], tv[1], tv[2], tv[3], tv[4]);
                tick();
                flag_seq($sformatf("R3 repeat level %0d miss", n), 1'b0);
            end
        end
    endtask

    task automatic t_undef();   // R4
        prog(5'b00001, base[3]);
        set_time(8'h11, 8'h22, 8'h03, 8'h04, 8'h05);
        tick();
        flag_seq("R4 undefined code seconds-only", 1'b1);
        prog(5'b10100, base[3]);
        tick();
        flag_seq("R4 undefined code gapped", 1'b1);
    endtask

    task automatic t_disable(); // R5
        prog(5'b00001, 8'h00);
        set_time(8'h11, 8'h22, 8'h03, 8'h04, 8'h05);
        tick();
        flag_seq("R5 disabled despite second repeat", 1'b0);
        prog(5'b00000, 8'h00);
        set_time(base[0], base[1], base[2], 8'h00, base[4]);
        tick();
        flag_seq("R5 disabled despite full match", 1'b0);
    endtask

    task automatic t_irq();     // R6, R8
        logic [7:0] d;
        prog(5'b11111, base[3]);
        wr(4'h1, 8'h00);
        tick();
        chk("R6 no enable pin high", {7'b0, irq_ft_n}, 8'h01);
        flag_seq("R6 flag without enable", 1'b1);
        wr(4'h1, 8'h80);
        tick();
        chk("R6 enable pin low", {7'b0, irq_ft_n}, 8'h00);
        rd(4'h0, d); chk("R8 first read flag", d, 8'h40);
        chk("R8 pin released", {7'b0, irq_ft_n}, 8'h01);
        rd(4'h0, d); chk("R8 second read flag", d, 8'h40);
        rd(4'h0, d); chk("R8 third read clear", d, 8'h00);
    endtask

    task automatic t_backup();  // R7
        prog(5'b11111, base[3]);
        backup_mode = 1'b1;
        wr(4'h1, 8'h80);
        tick();
        chk("R7 backup without abe", {7'b0, irq_ft_n}, 8'h01);
        flag_seq("R7 backup flag", 1'b1);
        wr(4'h1, 8'hC0);
        tick();
        chk("R7 backup with abe", {7'b0, irq_ft_n}, 8'h00);
        flag_seq("R7 backup clear", 1'b1);
        backup_mode = 1'b0;
        wr(4'h1, 8'h80);
        tick();
        chk("R7 normal mode needs afe only", {7'b0, irq_ft_n}, 8'h00);
        flag_seq("R7 normal clear", 1'b1);
    endtask

    task automatic t_powerup(); // R9
        logic [7:0] d;
        wr(4'h1, 8'hC0);
        do_reset();
        rd(4'h1, d); chk("R9 enables cleared", d, 8'h00);
        rd(4'h2, d); chk("R9 alarm cleared", d, 8'h00);
        prog(5'b11111, base[3]);
        tick();
        chk("R9 alarm after reset pin high", {7'b0, irq_ft_n}, 8'h01);
        flag_seq("R9 alarm after reset sets flag", 1'b1);
    endtask

    task automatic t_pin();     // R10
        logic [7:0] d;
        ftest_en = 1'b1; ftest_wave = 1'b0; #1;
        chk("R10 wave low", {7'b0, irq_ft_n}, 8'h00);
        ftest_wave = 1'b1; #1;
        chk("R10 wave high", {7'b0, irq_ft_n}, 8'h01);
        wdog_irq = 1'b1; #1;
        chk("R10 watchdog overrides wave", {7'b0, irq_ft_n}, 8'h00);
        wdog_irq = 1'b0;
        wr(4'h1, 8'h80);
        tick();
        chk("R10 alarm overrides wave", {7'b0, irq_ft_n}, 8'h00);
        rd(4'h0, d);
        chk("R10 wave back after release", {7'b0, irq_ft_n}, 8'h01);
        rd(4'h0, d);
        ftest_en = 1'b0; ftest_wave = 1'b0; #1;
        chk("R10 test off pin high", {7'b0, irq_ft_n}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_exact();
        t_repeat();
        t_undef();
        t_disable();
        t_irq();
        t_backup();
        t_powerup();
        t_pin();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule